// File: doc/BRIEF.md
# Core Clock Gear and Gating Controller

This block derives the clock for a CPU core from a faster system clock. It does not produce a real clock. It produces two synchronous enables. `core_ce` marks the system-clock cycles in which the core may advance. `sys_ce` marks the cycles in which the system clock feed is live for the gear logic and for peripherals. A 2-bit gear field selects the core rate: the full system rate, one half, one quarter or one eighth.

Two low-power states sit on top of the gear:

- **Halt** closes only the core enable. Peripherals keep their clock. Halt ends on reset, NMI, a maskable interrupt or an external interrupt.
- **Sleep** stops the whole system clock feed, and with it the core enable. Only an external interrupt or reset ends sleep.

A new gear value is written through a one-cycle write strobe. It is applied at the next core-enable boundary, so the core never sees a shortened period.

Top module: `core_clk_gear`

## Requirements
- R1: With gear field value g (0, 1, 2, 3), `core_ce` is high in exactly one of every 2^g system-clock cycles. At g = 0 it is high in every cycle.
- R2: After reset the gear is 0, `pwr_state` is RUN (encoding 0), `sys_ce` is 1 and `core_ce` is 1 in every cycle.
- R3: A halt request while running moves `pwr_state` to HALT (encoding 1). In HALT, `core_ce` is 0 and `sys_ce` stays 1.
- R4: HALT returns to RUN on `nmi`, `irq`, `ext_irq` or reset, and `core_ce` then resumes at the selected gear.
- R5: A sleep request while running moves `pwr_state` to SLEEP (encoding 2). In SLEEP, both `sys_ce` and `core_ce` are 0.
- R6: In SLEEP, `nmi` and `irq` have no effect. Only `ext_irq` or reset returns the block to RUN.
- R7: A gear write takes effect only at the next `core_ce` pulse. The first period at the new gear is a full 2^g cycles long.
- R8: The divider is held cleared in SLEEP. The first `core_ce` after waking comes in the 2^g-th cycle after the wake edge.
- R9: If halt and sleep are requested in the same cycle, the block enters SLEEP.
- R10: A wake source that is already asserted when halt or sleep is requested keeps the block in RUN. For halt, that means any of the three interrupts. For sleep, it means `ext_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also a wake source |
| gear_wr_en | input | 1 | One-cycle write strobe for the gear field |
| gear_wr_data | input | 2 | New gear value: 0 = 1/1, 1 = 1/2, 2 = 1/4, 3 = 1/8 |
| halt_req | input | 1 | Request to enter HALT |
| sleep_req | input | 1 | Request to enter SLEEP |
| nmi | input | 1 | Non-maskable interrupt, wakes from HALT |
| irq | input | 1 | Enabled maskable interrupt, wakes from HALT |
| ext_irq | input | 1 | External interrupt, wakes from HALT or SLEEP |
| core_ce | output | 1 | Core clock enable |
| sys_ce | output | 1 | System clock feed enable |
| pwr_state | output | 2 | 0 = RUN, 1 = HALT, 2 = SLEEP |

## Verification
The gear is tried with every ratio, in a mixed order that includes repeats. Counting pulses over a fixed 32-cycle window tells each ratio apart, and it also shows that a repeated or reordered write lands on the right value.

Wake tests apply each interrupt source separately in each low-power state. This separates the halt wake set from the sleep wake set. Collisions between requests and wake sources, and the timing of pulses around a gear change or a sleep exit, expose phase errors that a pulse count alone would miss.

// File: rtl/ccg_pkg.sv
// Shared types for the core clock gear controller.
// Assumes the power-state encoding is visible at the top-level port.
package ccg_pkg;
    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_HALT  = 2'd1,
        PWR_SLEEP = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/ccg_pwr_fsm.sv
// Power-state machine: RUN, HALT and SLEEP.
// Sleep has priority over halt. A request is refused while a matching
// wake source is already asserted. Assumes all inputs are synchronous to clk.
module ccg_pwr_fsm
    import ccg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       sleep_req,
    input  logic       nmi,
    input  logic       irq,
    input  logic       ext_irq,
    output pwr_state_t state
);
    pwr_state_t state_q, state_d;
    logic       halt_wake;

    // Any interrupt source ends halt.
    assign halt_wake = nmi | irq | ext_irq;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (sleep_req) begin
                    if (!ext_irq) state_d = PWR_SLEEP;
                end else if (halt_req && !halt_wake) begin
                    state_d = PWR_HALT;
                end
            end
            PWR_HALT:  if (halt_wake) state_d = PWR_RUN;
            PWR_SLEEP: if (ext_irq)   state_d = PWR_RUN;
            default:   state_d = PWR_RUN;
        endcase
    end

    // State register, reset returns to RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/ccg_gear_reg.sv
// Gear field with a pending copy.
// A write lands in the pending copy and is moved into the active gear
// only on a boundary cycle. Assumes boundary is high on core-enable cycles.
module ccg_gear_reg #(
    parameter int GEAR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GEAR_W-1:0] wr_data,
    input  logic              boundary,
    output logic [GEAR_W-1:0] gear,
    output logic              commit
);
    logic [GEAR_W-1:0] pend_q, active_q;
    logic              pend_vld_q;

    // Apply a pending value on the boundary.
    assign commit = pend_vld_q & boundary;

    // Pending and active gear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            active_q   <= '0;
        end else begin
            if (commit) active_q <= pend_q;
            if (wr_en) begin
                pend_q     <= wr_data;
                pend_vld_q <= 1'b1;
            end else if (commit) begin
                pend_vld_q <= 1'b0;
            end
        end
    end

    assign gear = active_q;
endmodule

// File: rtl/ccg_divider.sv
// Free-running divider counter with tick decode.
// The tick is high when the low `gear` counter bits are all ones.
// The counter is cleared while held, and on restart.
module ccg_divider #(
    parameter int GEAR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEAR_W-1:0] gear,
    input  logic              hold,
    input  logic              restart,
    output logic              tick
);
    localparam int CNT_W = (1 << GEAR_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Counter: cleared on reset, hold or restart, otherwise counts up.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || restart) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    // Mask of the low counter bits for the selected gear.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (32'(gear) > i);
    end

    assign tick = ((cnt_q & mask) == mask);
endmodule

// File: rtl/core_clk_gear.sv
// Core clock gear and gating controller (top).
// The core enable is the divider tick, passed only in RUN. The system
// enable is off only in SLEEP. Assumes a single clock domain and
// synchronous active-low reset.
module core_clk_gear
    import ccg_pkg::*;
#(
    parameter int GEAR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gear_wr_en,
    input  logic [GEAR_W-1:0] gear_wr_data,
    input  logic              halt_req,
    input  logic              sleep_req,
    input  logic              nmi,
    input  logic              irq,
    input  logic              ext_irq,
    output logic              core_ce,
    output logic              sys_ce,
    output logic [1:0]        pwr_state
);
    pwr_state_t        state;
    logic [GEAR_W-1:0] gear;
    logic              tick, commit, asleep;

    ccg_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .sleep_req (sleep_req),
        .nmi       (nmi),
        .irq       (irq),
        .ext_irq   (ext_irq),
        .state     (state)
    );

    // Gear changes are committed only on a live tick.
    ccg_gear_reg #(.GEAR_W(GEAR_W)) u_gear (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (gear_wr_en),
        .wr_data  (gear_wr_data),
        .boundary (tick & ~asleep),
        .gear     (gear),
        .commit   (commit)
    );

    ccg_divider #(.GEAR_W(GEAR_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .gear    (gear),
        .hold    (asleep),
        .restart (commit),
        .tick    (tick)
    );

    // Output enables.
    assign asleep    = (state == PWR_SLEEP);
    assign sys_ce    = ~asleep;
    assign core_ce   = tick & (state == PWR_RUN);
    assign pwr_state = state;
endmodule

// File: rtl/core_clk_gear_chk.sv
// Assertion checker for core_clk_gear, attached by bind.
module core_clk_gear_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       sleep_req,
    input logic       nmi,
    input logic       irq,
    input logic       ext_irq,
    input logic       core_ce,
    input logic       sys_ce,
    input logic [1:0] pwr_state
);
    localparam logic [1:0] ST_RUN = 2'd0, ST_HALT = 2'd1, ST_SLEEP = 2'd2;

    AST_HALT_SYS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == ST_HALT |-> sys_ce && !core_ce); // R3
    AST_HALT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == ST_HALT && (nmi || irq || ext_irq)) |=> pwr_state == ST_RUN); // R4
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == ST_SLEEP |-> !sys_ce && !core_ce); // R5
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == ST_SLEEP && !ext_irq) |=> pwr_state == ST_SLEEP); // R6
    AST_SLEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == ST_RUN && sleep_req && halt_req && !ext_irq) |=> pwr_state == ST_SLEEP); // R9
    AST_NO_LOST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == ST_RUN && !sleep_req && halt_req && (nmi || irq || ext_irq))
        |=> pwr_state == ST_RUN); // R10
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'd3); // R2
endmodule

bind core_clk_gear core_clk_gear_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .sleep_req (sleep_req),
    .nmi       (nmi),
    .irq       (irq),
    .ext_irq   (ext_irq),
    .core_ce   (core_ce),
    .sys_ce    (sys_ce),
    .pwr_state (pwr_state)
);

// File: tb/core_clk_gear_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for core_clk_gear.
module core_clk_gear_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gear_wr_en = 1'b0;
    logic [1:0] gear_wr_data = 2'd0;
    logic       halt_req = 1'b0, sleep_req = 1'b0;
    logic       nmi = 1'b0, irq = 1'b0, ext_irq = 1'b0;
    logic       core_ce, sys_ce;
    logic [1:0] pwr_state;

    int n_checks = 0;
    int n_fail   = 0;

    // Each entry: {gear[7:6], expected pulses in 32 cycles [5:0]}.
    localparam logic [7:0] VEC [6] = '{
        {2'd0, 6'd32}, {2'd3, 6'd4}, {2'd1, 6'd16},
        {2'd2, 6'd8},  {2'd0, 6'd32}, {2'd2, 6'd8}
    };

    always #2.5 clk = ~clk;

    core_clk_gear dut_i (
        .clk(clk), .rst_n(rst_n), .gear_wr_en(gear_wr_en), .gear_wr_data(gear_wr_data),
        .halt_req(halt_req), .sleep_req(sleep_req), .nmi(nmi), .irq(irq),
        .ext_irq(ext_irq), .core_ce(core_ce), .sys_ce(sys_ce), .pwr_state(pwr_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_gear(input logic [1:0] g);
        gear_wr_data = g; gear_wr_en = 1'b1;
        step(1);
        gear_wr_en = 1'b0;
        step(16);
    endtask

    function automatic int count_pulses_expected(input int g);
        return 32 >> g;
    endfunction

    task automatic count_pulses(output int cnt);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            if (core_ce) cnt++;
            step(1);
        end
    endtask

    task automatic pulse_req(input bit h, input bit s);
        halt_req = h; sleep_req = s;
        step(1);
        halt_req = 1'b0; sleep_req = 1'b0;
    endtask

    int   cnt, t0, t1, t2, t3;
    logic seen;

    initial begin : watchdog
        #400us;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);

        // R2: reset state
        check(pwr_state == 2'd0, "R2 state", pwr_state, 0);
        check(sys_ce == 1'b1, "R2 sys_ce", sys_ce, 1);
        count_pulses(cnt);
        check(cnt == 32, "R2 full speed", cnt, 32);

        // R1: vector table walk
        foreach (VEC[k]) begin
            write_gear(VEC[k][7:6]);
            count_pulses(cnt);
            check(cnt == int'(VEC[k][5:0]) && cnt == count_pulses_expected(VEC[k][7:6]),
                  "R1 gear ratio", cnt, int'(VEC[k][5:0]));
        end

        // R3: halt gates the core only (gear 2 active)
        pulse_req(1'b1, 1'b0);
        check(pwr_state == 2'd1, "R3 state", pwr_state, 1);
        count_pulses(cnt);
        check(cnt == 0 && sys_ce, "R3 core gated", cnt, 0);

        // R4: irq ends halt, gear resumes
        irq = 1'b1; step(1); irq = 1'b0;
        check(pwr_state == 2'd0, "R4 irq wake", pwr_state, 0);
        count_pulses(cnt);
        check(cnt == 8, "R4 resume gear", cnt, 8);

        // R4: nmi ends halt
        pulse_req(1'b1, 1'b0);
        step(3);
        nmi = 1'b1; step(1); nmi = 1'b0;
        check(pwr_state == 2'd0, "R4 nmi wake", pwr_state, 0);

        // R4: reset ends halt
        pulse_req(1'b1, 1'b0);
        step(2);
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        check(pwr_state == 2'd0, "R4 reset wake", pwr_state, 0);
        write_gear(2'd2);

        // R10: halt with irq already high stays in RUN
        irq = 1'b1; pulse_req(1'b1, 1'b0); irq = 1'b0;
        check(pwr_state == 2'd0, "R10 halt refused", pwr_state, 0);

        // R10: sleep with ext_irq already high stays in RUN
        ext_irq = 1'b1; pulse_req(1'b0, 1'b1); ext_irq = 1'b0;
        check(pwr_state == 2'd0, "R10 sleep refused", pwr_state, 0);

        // R5: sleep stops both enables
        pulse_req(1'b0, 1'b1);
        check(pwr_state == 2'd2, "R5 state", pwr_state, 2);
        check(!sys_ce && !core_ce, "R5 enables off", {sys_ce, core_ce}, 0);

        // R6: nmi and irq do not end sleep
        nmi = 1'b1; irq = 1'b1; step(3); nmi = 1'b0; irq = 1'b0;
        check(pwr_state == 2'd2 && !sys_ce, "R6 ignored wakes", pwr_state, 2);

        // R8: first pulse after wake at cycle 4 for gear 2
        ext_irq = 1'b1; step(1); ext_irq = 1'b0;
        check(pwr_state == 2'd0 && sys_ce, "R6 ext wake", pwr_state, 0);
        t0 = 1; seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            if (core_ce) seen = 1'b1; else begin t0++; step(1); end
        end
        check(t0 == 4, "R8 wake phase", t0, 4);

        // R6: reset ends sleep
        pulse_req(1'b0, 1'b1);
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        check(pwr_state == 2'd0 && sys_ce, "R6 reset wake", pwr_state, 0);

        // R9: simultaneous halt and sleep enter sleep
        pulse_req(1'b1, 1'b1);
        check(pwr_state == 2'd2, "R9 sleep priority", pwr_state, 2);
        ext_irq = 1'b1; step(1); ext_irq = 1'b0;

        // R7: gear change at a boundary, 1/8 to 1/2
        write_gear(2'd3);
        while (!core_ce) step(1);
        t0 = 0; step(3);
        gear_wr_data = 2'd1; gear_wr_en = 1'b1; step(1); gear_wr_en = 1'b0;
        t1 = 4; t2 = 0; t3 = 0;
        for (int i = 0; i < 16; i++) begin
            if (core_ce) begin
                if (t2 == 0) t2 = t1;
                else if (t3 == 0) t3 = t1;
            end
            t1++; step(1);
        end
        check(t2 == 8, "R7 old period kept", t2, 8);
        check(t3 - t2 == 2, "R7 new period full", t3 - t2, 2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule